// File: doc/BRIEF.md
# Two-Stage Selectable Clock-Enable Divider

This block divides one source clock in two cascaded stages and produces single-cycle clock-enable pulses rather than derived clocks. The first stage is a power-of-two predivider. The second stage counts predivider pulses and offers a ratio set that includes odd and non-power-of-two values. The main output pulses once per product of the two ratios. Timer logic downstream can also pick from a fixed set of taps: the undivided clock, divide-by-4 and divide-by-64. These taps run from their own free-running counter and do not depend on the ratio codes.

Every counter lives in one small state machine with two named states. `ST_LOAD` is the single cycle after reset: the stage captures the ratio from its code input, clears its counter and drives no pulse, then moves on. `ST_COUNT` is the running state: the counter advances on each qualifying cycle and reloads at the terminal count, which is also when a new ratio code is captured. There is no other transition, apart from the asynchronous return to `ST_LOAD` on reset. Interval *n* below is the clock period after the *n*-th rising edge with reset released, counting from 0. Interval 0 is the `ST_LOAD` cycle and has no pulses.

Top module: `clk_div2stage`

## Requirements
- R1: While `rst_n` is low, `pre_en`, `out_en` and all three tap outputs are low.
- R2: `pre_sel` codes 0, 1, 2, 3 select predivider ratio P = 1, 2, 4, 8. With a constant code, `pre_en` is high during every interval *n* ≥ 1 with (*n* − 1) mod P = P − 1, and low otherwise.
- R3: `out_sel` codes 0..7 select the second-stage ratio Q = 1, 2, 3, 4, 8, 12, 24, 64 in that order. With constant codes, `out_en` is high during every interval *n* ≥ 1 with (*n* − 1) mod (P·Q) = P·Q − 1. `out_en` is never high without `pre_en`.
- R4: With both codes 0, `pre_en` and `out_en` are high in every interval from 1 onward.
- R5: A stage captures its code only on the edge at the end of an interval in which its pulse is high, and once at the end of interval 0. A code present at that edge sets the length of the period that follows.
- R6: Code changes at any other time have no effect on the current period: the pulse timing of the running period is unchanged.
- R7: `tap_x1_en` is high in every interval from 1 onward. `tap_x4_en` is high when (*n* − 1) mod 4 = 3. `tap_x64_en` is high when (*n* − 1) mod 64 = 63. The taps are independent of both codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Predivider ratio code |
| out_sel | input | 3 | Second-stage ratio code |
| pre_en | output | 1 | Predivider enable pulse |
| out_en | output | 1 | Main divided enable pulse |
| tap_x1_en | output | 1 | Undivided tap enable |
| tap_x4_en | output | 1 | Divide-by-4 tap enable |
| tap_x64_en | output | 1 | Divide-by-64 tap enable |

## Verification
The hardest case to reach from the ports is a code change that lands exactly in the cycle of a terminal pulse. It has to be told apart from a change one cycle earlier or later. This matters most for the second stage, whose terminal cycle comes round only once per P·Q cycles.

The bench runs a reference counter model alongside the design. It uses that model to find the interval in which a pulse is due and drives new codes in that same interval. It also fires random code changes in the middle of periods, so the capture and ignore cases are both exercised many times.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    localparam int PRE_CODE_W = 2;
    localparam int OUT_CODE_W = 3;
    localparam int RATIO_W    = 7;   // holds ratio 64
    localparam int TAP_N      = 3;
    localparam int TAP_CNT_W  = 6;   // enough for the divide-by-64 tap

    typedef enum logic {
        ST_LOAD  = 1'b0,
        ST_COUNT = 1'b1
    } div_state_e;

    function automatic logic [RATIO_W-1:0] pre_ratio(input logic [PRE_CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        r = RATIO_W'(1) << code;
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] out_ratio(input logic [OUT_CODE_W-1:0] code);
        logic [RATIO_W-1:0] r;
        unique case (code)
            3'd0: r = RATIO_W'(1);
            3'd1: r = RATIO_W'(2);
            3'd2: r = RATIO_W'(3);
            3'd3: r = RATIO_W'(4);
            3'd4: r = RATIO_W'(8);
            3'd5: r = RATIO_W'(12);
            3'd6: r = RATIO_W'(24);
            default: r = RATIO_W'(64);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/div_stage.sv
`timescale 1ns/1ps
module div_stage
    import clkdiv_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] ratio_in,
    output logic         tick
);

    div_state_e state_q, state_d;
    logic [W-1:0] ratio_q;
    logic [W-1:0] cnt_q;
    logic         at_term;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = ST_COUNT;
            ST_COUNT: state_d = ST_COUNT;
            default:  state_d = ST_LOAD;
        endcase
    end

    // counter and ratio capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= W'(1);
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    ratio_q <= ratio_in;
                    cnt_q   <= '0;
                end
                ST_COUNT: begin
                    if (adv) begin
                        if (at_term) begin
                            cnt_q   <= '0;
                            ratio_q <= ratio_in;
                        end else begin
                            cnt_q <= cnt_q + W'(1);
                        end
                    end
                end
                default: begin
                    ratio_q <= W'(1);
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        at_term = (cnt_q == (ratio_q - W'(1)));
        tick    = (state_q == ST_COUNT) && adv && at_term;
    end

    // R2: the running count stays below the captured ratio
    a_r2_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q < ratio_q));

    // R6: the ratio holds across every non-terminal running cycle
    a_r6_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !tick) |=> $stable(ratio_q));

endmodule

// File: rtl/tap_gen.sv
`timescale 1ns/1ps
module tap_gen
    import clkdiv_pkg::*;
#(
    parameter int N     = 3,
    parameter int CNT_W = 6,
    parameter int unsigned LOG2 [N] = '{0, 2, 6}
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [N-1:0] tap
);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = ST_COUNT;
            ST_COUNT: state_d = ST_COUNT;
            default:  state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q == ST_COUNT) cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar g = 0; g < N; g++) begin : g_tap
        localparam logic [CNT_W-1:0] MASK = CNT_W'((64'd1 << LOG2[g]) - 64'd1);
        always_comb begin
            tap[g] = (state_q == ST_COUNT) && ((cnt_q & MASK) == MASK);
        end
    end

    // R7: the slowest tap only fires together with the middle tap
    a_r7_tap_nested: assert property (@(posedge clk) disable iff (!rst_n)
        tap[N-1] |-> tap[1]);

    // R7: the middle tap never fires in two adjacent cycles
    a_r7_tap_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tap[1] |=> !tap[1]);

endmodule

// File: rtl/clk_div2stage.sv
`timescale 1ns/1ps
module clk_div2stage
    import clkdiv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRE_CODE_W-1:0] pre_sel,
    input  logic [OUT_CODE_W-1:0] out_sel,
    output logic                  pre_en,
    output logic                  out_en,
    output logic                  tap_x1_en,
    output logic                  tap_x4_en,
    output logic                  tap_x64_en
);

    logic [RATIO_W-1:0] pre_r;
    logic [RATIO_W-1:0] out_r;
    logic [TAP_N-1:0]   taps;

    always_comb begin
        pre_r = pre_ratio(pre_sel);
        out_r = out_ratio(out_sel);
    end

    div_stage #(.W(RATIO_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (1'b1),
        .ratio_in (pre_r),
        .tick     (pre_en)
    );

    div_stage #(.W(RATIO_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (pre_en),
        .ratio_in (out_r),
        .tick     (out_en)
    );

    tap_gen #(.N(TAP_N), .CNT_W(TAP_CNT_W), .LOG2('{0, 2, 6})) u_taps (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (taps)
    );

    assign tap_x1_en  = taps[0];
    assign tap_x4_en  = taps[1];
    assign tap_x64_en = taps[2];

    // R3: the main output only pulses on a predivider pulse
    a_r3_out_on_pre: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> pre_en);

endmodule

// File: tb/clk_div2stage_tb.sv
`timescale 1ns/1ps
module clk_div2stage_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [2:0] out_sel = 3'd0;
    logic       pre_en, out_en, tap_x1_en, tap_x4_en, tap_x64_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    clk_div2stage dut_i (
        .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .out_sel(out_sel),
        .pre_en(pre_en), .out_en(out_en), .tap_x1_en(tap_x1_en),
        .tap_x4_en(tap_x4_en), .tap_x64_en(tap_x64_en)
    );

    function automatic int f_pre(input logic [1:0] c);
        return 1 << c;
    endfunction

    function automatic int f_out(input logic [2:0] c);
        int t [8] = '{1, 2, 3, 4, 8, 12, 24, 64};
        return t[c];
    endfunction

    // reference model: interval counters
    bit m_run = 1'b0;
    int m_p = 1, m_q = 1, m_pc = 0, m_oc = 0, m_n = 0;

    function automatic bit e_pre();
        return m_run && (m_pc == m_p - 1);
    endfunction
    function automatic bit e_out();
        return e_pre() && (m_oc == m_q - 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1'b0; m_pc = 0; m_oc = 0; m_n = 0;
        end else if (!m_run) begin
            m_run = 1'b1;
            m_p = f_pre(pre_sel); m_q = f_out(out_sel);
            m_pc = 0; m_oc = 0; m_n = 0;
        end else begin
            if (e_pre()) begin
                if (m_oc == m_q - 1) begin m_oc = 0; m_q = f_out(out_sel); end
                else m_oc = m_oc + 1;
                m_pc = 0; m_p = f_pre(pre_sel);
            end else begin
                m_pc = m_pc + 1;
            end
            m_n = m_n + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    // one negedge: compare all outputs, leave drive to caller
    task automatic step(input string tag);
        @(negedge clk);
        if (!rst_n) begin
            chk("R1", "pre_en", pre_en, 1'b0);
            chk("R1", "out_en", out_en, 1'b0);
            chk("R1", "taps", tap_x1_en | tap_x4_en | tap_x64_en, 1'b0);
        end else begin
            chk(tag, "pre_en", pre_en, e_pre());
            chk(tag, "out_en", out_en, e_out());
            chk("R7", "tap_x1_en", tap_x1_en, m_run);
            chk("R7", "tap_x4_en", tap_x4_en, m_run && (m_n % 4 == 3));
            chk("R7", "tap_x64_en", tap_x64_en, m_run && (m_n % 64 == 63));
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        // R1: outputs low in reset
        repeat (4) step("R1");
        rst_n = 1'b1;

        // R4: both stages at divide-by-1
        pre_sel = 2'd0; out_sel = 3'd0;
        repeat (20) step("R4");

        // R2/R3: every code pair held for two full periods
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 8; q++) begin
                pre_sel = 2'(p); out_sel = 3'(q);
                repeat (2 * f_pre(2'(p)) * f_out(3'(q)) + 4)
                    step((p == 0 && q == 0) ? "R4" : ((q == 0) ? "R2" : "R3"));
            end
        end

        // R5: new codes driven exactly in the terminal interval
        for (int k = 0; k < 40; k++) begin
            int guard = 0;
            do begin
                step("R5");
                guard++;
            end while (!e_out() && guard < 600);
            pre_sel = 2'($urandom_range(0, 3));
            out_sel = 3'($urandom_range(0, 7));
            repeat (3) step("R5");
        end

        // R6: frequent random changes in the middle of periods
        for (int k = 0; k < 8000; k++) begin
            step("R6");
            if ($urandom_range(0, 3) == 0) begin
                pre_sel = 2'($urandom_range(0, 3));
                out_sel = 3'($urandom_range(0, 7));
            end
        end

        // R1: reset in the middle of a run
        pre_sel = 2'd1; out_sel = 3'd2;
        repeat (7) step("R3");
        rst_n = 1'b0;
        repeat (3) step("R1");
        rst_n = 1'b1;
        repeat (40) step("R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule